// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Functional Model

This block is a synthesizable functional stand-in for a 16-bit-wide static RAM controlled by five active-low pins: a chip select, an output enable, a write enable and one enable for each byte lane. It runs on a fast sampling clock. On every rising edge it samples the pins and decides, separately for each byte lane, whether that lane is read, written or left quiet. It can replace an external asynchronous memory inside a chip or an FPGA test setup, or it can serve as a target for a memory controller under test.

There is no tristate bus. The model has a separate write-data input and a read-data output. A lane-enable vector marks which lanes would be driving a real bus. A lane that is not driving reads as zero. The depth is a parameter. Set `ADDR_W` to 16 for the full 65,536-word array; the default is smaller so that the model elaborates quickly. Another parameter selects the read path: either a combinational read of the array, or a read registered by one sampling clock.

Top module: `lane_sram_model`

## Requirements
- R1: While `cs_n` is 1, `lane_oe` is 2'b00, `rdata` is zero, and no stored byte changes, whatever the other pins are.
- R2: With `cs_n`=0, `we_n`=1 and `oe_n`=0, each lane whose `be_n` bit is 0 asserts its `lane_oe` bit and presents its stored byte. A lane whose `be_n` bit is 1 stays off.
- R3: With `cs_n`=0 and `we_n`=0, each lane whose `be_n` bit is 0 stores its byte of `wdata` at `addr`. `oe_n` has no effect, and `lane_oe` is 2'b00.
- R4: With `cs_n`=0 and `we_n`=1, both lanes are off if `oe_n` is 1 or if both `be_n` bits are 1.
- R5: Lane 0 is data bits 7:0 and is controlled by `be_n[0]` and `lane_oe[0]`. Lane 1 is data bits 15:8 and is controlled by `be_n[1]` and `lane_oe[1]`.
- R6: When `READ_REG`=1, `rdata` and `lane_oe` reflect the pins sampled at the previous rising edge. A lane whose `lane_oe` bit is 0 always shows zero on its `rdata` bits.
- R7: A write commits on every sampling edge while the write condition holds. The stored value is the data present at the last edge of the write.
- R8: A read that follows a byte write to the same address returns the new byte only in the lanes that were written. Every other lane keeps its earlier value.
- R9: While `rst` is high, and on the first cycle after it, `lane_oe` is 2'b00 and `rdata` is zero. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; takes priority over output enable |
| be_n | input | LANES | Per-lane byte enables, active low; bit 0 is the low lane |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data; zero in lanes that are not driving |
| lane_oe | output | LANES | Per-lane flag meaning the lane would drive the bus |

## Verification
The hardest case to reach from the ports is a single write held across several sampling edges while its data changes, combined with byte writes into words whose other lane must survive. The bench drives these directly. It holds a write for three edges with different data and then reads back. It writes a full word, overwrites one lane, and reads each lane alone. It also checks that a write attempted while deselected leaves the word intact. A long random phase then draws controls and addresses from a small pool of preloaded words, so that reads, partial writes and writes to the same address follow each other often. A behavioural model checks every cycle.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

  // Decoded chip-level operation for one sampling edge
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
  import sram_model_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic [LANES-1:0] be_n,
  output sram_op_e         op,
  output logic [LANES-1:0] lane_wr,
  output logic [LANES-1:0] lane_rd
);

  // Write enable wins over output enable; deselect wins over everything
  always_comb begin
    if (cs_n)        op = OP_IDLE;
    else if (!we_n)  op = OP_WRITE;
    else if (!oe_n)  op = OP_READ;
    else             op = OP_IDLE;
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_wr[l] = (op == OP_WRITE) && !be_n[l];
      assign lane_rd[l] = (op == OP_READ)  && !be_n[l];
    end
  endgenerate

endmodule

// File: rtl/sram_byte_bank.sv
module sram_byte_bank #(
  parameter int ADDR_W   = 10,
  parameter int LANE_W   = 8,
  parameter bit READ_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout,
  output logic              drive
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // Single write port, one byte wide, written on every enabled edge
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= din;
  end

  generate
    if (READ_REG) begin : g_reg_rd
      logic [LANE_W-1:0] dout_q;
      logic              drive_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          dout_q  <= '0;
          drive_q <= 1'b0;
        end else begin
          dout_q  <= rd_en ? mem[addr] : '0;
          drive_q <= rd_en;
        end
      end
      assign dout  = dout_q;
      assign drive = drive_q;
    end else begin : g_comb_rd
      logic unused_rst;
      assign unused_rst = rst;
      assign dout  = rd_en ? mem[addr] : '0;
      assign drive = rd_en;
    end
  endgenerate

endmodule

// File: rtl/lane_sram_model.sv
module lane_sram_model
  import sram_model_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int LANE_W   = 8,
  parameter int LANES    = 2,
  parameter bit READ_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_n,
  input  logic                    oe_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        be_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        lane_oe
);

  sram_op_e         op;
  logic [LANES-1:0] lane_wr;
  logic [LANES-1:0] lane_rd;

  sram_ctrl_decode #(.LANES(LANES)) dec_i (
    .cs_n    (cs_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .be_n    (be_n),
    .op      (op),
    .lane_wr (lane_wr),
    .lane_rd (lane_rd)
  );

  logic [1:0] unused_op;
  assign unused_op = op;

  // One independent byte-wide bank per lane; lane l owns bits l*LANE_W upward
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_bank
      sram_byte_bank #(
        .ADDR_W   (ADDR_W),
        .LANE_W   (LANE_W),
        .READ_REG (READ_REG)
      ) bank_i (
        .clk   (clk),
        .rst   (rst),
        .wr_en (lane_wr[l]),
        .rd_en (lane_rd[l]),
        .addr  (addr),
        .din   (wdata[l*LANE_W +: LANE_W]),
        .dout  (rdata[l*LANE_W +: LANE_W]),
        .drive (lane_oe[l])
      );
    end
  endgenerate

endmodule

// File: rtl/lane_sram_chk.sv
module lane_sram_chk #(
  parameter int LANE_W   = 8,
  parameter int LANES    = 2,
  parameter bit READ_REG = 1'b1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cs_n,
  input logic                    oe_n,
  input logic                    we_n,
  input logic [LANES-1:0]        be_n,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic [LANES-1:0]        lane_oe
);

  generate
    if (READ_REG) begin : g_reg
      a_r1_deselect_off: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (lane_oe == '0));
      a_r3_write_off: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !we_n) |=> (lane_oe == '0));
      a_r4_oe_high_off: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && (oe_n || (&be_n))) |=> (lane_oe == '0));
      a_r2_lane_follows_be: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && !oe_n) |=> (lane_oe == ~$past(be_n)));
    end else begin : g_comb
      a_r1_deselect_off: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (lane_oe == '0));
      a_r3_write_off: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !we_n) |-> (lane_oe == '0));
      a_r4_oe_high_off: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && (oe_n || (&be_n))) |-> (lane_oe == '0));
      a_r2_lane_follows_be: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && !oe_n) |-> (lane_oe == ~be_n));
    end
    for (genvar l = 0; l < LANES; l++) begin : g_quiet
      a_r6_quiet_lane_zero: assert property (@(posedge clk) disable iff (rst)
        !lane_oe[l] |-> (rdata[l*LANE_W +: LANE_W] == '0));
    end
  endgenerate

endmodule

bind lane_sram_model lane_sram_chk #(
  .LANE_W   (LANE_W),
  .LANES    (LANES),
  .READ_REG (READ_REG)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .oe_n    (oe_n),
  .we_n    (we_n),
  .be_n    (be_n),
  .rdata   (rdata),
  .lane_oe (lane_oe)
);

// File: tb/lane_sram_model_tb_top.sv
`timescale 1ns/1ps
module lane_sram_model_tb_top;

  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n, oe_n, we_n;
  logic [1:0]  be_n;
  logic [AW-1:0] addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [1:0]  lane_oe;

  int checks   = 0;
  int failures = 0;
  bit running  = 1'b0;

  always #2 clk = ~clk;

  lane_sram_model #(.ADDR_W(AW), .LANE_W(8), .LANES(2), .READ_REG(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .be_n(be_n), .addr(addr), .wdata(wdata), .rdata(rdata), .lane_oe(lane_oe)
  );

  // Behavioural reference: word store plus expected outputs after each edge
  logic [15:0] ref_mem [int];
  logic [15:0] exp_data;
  logic [1:0]  exp_oe;
  string       exp_tag;

  always @(posedge clk) begin
    logic [15:0] d;
    logic [1:0]  o;
    int a;
    d = 16'h0; o = 2'b00; a = int'(addr);
    if (rst) begin
      exp_tag = "R9";
    end else begin
      if (cs_n)                 exp_tag = "R1";
      else if (!we_n)           exp_tag = "R3";
      else if (oe_n || &be_n)   exp_tag = "R4";
      else                      exp_tag = "R2";
      if (!cs_n && we_n && !oe_n) begin
        for (int l = 0; l < 2; l++)
          if (!be_n[l]) begin
            o[l] = 1'b1;
            d[l*8 +: 8] = ref_mem.exists(a) ? ref_mem[a][l*8 +: 8] : 8'hxx;
          end
      end
      if (!cs_n && !we_n) begin
        if (!ref_mem.exists(a)) ref_mem[a] = 16'h0000;
        for (int l = 0; l < 2; l++)
          if (!be_n[l]) ref_mem[a][l*8 +: 8] = wdata[l*8 +: 8];
      end
    end
    exp_data = d;
    exp_oe   = o;
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (rdata !== exp_data || lane_oe !== exp_oe) begin
        failures++;
        $display("FAIL %s cycle compare: rdata=%h lane_oe=%b expected rdata=%h lane_oe=%b",
                 exp_tag, rdata, lane_oe, exp_data, exp_oe);
      end
    end
  end

  task automatic drive(input logic c, input logic o, input logic w,
                       input logic [1:0] b, input logic [AW-1:0] a,
                       input logic [15:0] d);
    cs_n = c; oe_n = o; we_n = w; be_n = b; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [1:0] eo,
                            input logic [15:0] ed);
    checks++;
    if (rdata !== ed || lane_oe !== eo) begin
      failures++;
      $display("FAIL %s directed: rdata=%h lane_oe=%b expected rdata=%h lane_oe=%b",
               tag, rdata, lane_oe, ed, eo);
    end
  endtask

  function automatic logic [AW-1:0] pool_addr(input int k);
    return (k == 16) ? {AW{1'b1}} : AW'(k);
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    be_n = 2'b11; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_out("R9", 2'b00, 16'h0000);          // R9 outputs quiet in reset
    rst = 1'b0;
    running = 1'b1;

    // Preload the address pool with full-word writes
    for (int k = 0; k <= 16; k++)
      drive(1'b0, 1'b0, 1'b0, 2'b00, pool_addr(k), 16'h1000 + 16'(k * 16'h0101));
    expect_out("R3", 2'b00, 16'h0000);          // R3 writes never drive, oe_n=0 ignored

    // R8 byte write then per-lane read-back
    drive(1'b0, 1'b1, 1'b0, 2'b00, 10'd3, 16'hA5C3);
    drive(1'b0, 1'b1, 1'b0, 2'b10, 10'd3, 16'hFF11);
    drive(1'b0, 1'b0, 1'b1, 2'b00, 10'd3, 16'h0000);
    expect_out("R8", 2'b11, 16'hA511);
    drive(1'b0, 1'b0, 1'b1, 2'b01, 10'd3, 16'h0000);
    expect_out("R5", 2'b10, 16'hA500);          // R5 high lane only
    drive(1'b0, 1'b0, 1'b1, 2'b10, 10'd3, 16'h0000);
    expect_out("R5", 2'b01, 16'h0011);          // R5 low lane only

    // R1 write attempt while deselected changes nothing
    drive(1'b1, 1'b0, 1'b0, 2'b00, 10'd3, 16'hDEAD);
    expect_out("R1", 2'b00, 16'h0000);
    drive(1'b0, 1'b0, 1'b1, 2'b00, 10'd3, 16'h0000);
    expect_out("R1", 2'b11, 16'hA511);

    // R4 both byte enables high, and oe_n high
    drive(1'b0, 1'b0, 1'b1, 2'b11, 10'd3, 16'h0000);
    expect_out("R4", 2'b00, 16'h0000);
    drive(1'b0, 1'b1, 1'b1, 2'b00, 10'd3, 16'h0000);
    expect_out("R4", 2'b00, 16'h0000);

    // R7 write held for three edges with changing data; last one stays
    cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; be_n = 2'b00; addr = 10'd5;
    wdata = 16'h1111; @(posedge clk); @(negedge clk);
    wdata = 16'h2222; @(posedge clk); @(negedge clk);
    wdata = 16'h3C4D; @(posedge clk); @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 2'b00, 10'd5, 16'h0000);
    expect_out("R7", 2'b11, 16'h3C4D);

    // R6 one-cycle latency: outputs unchanged before the next edge
    cs_n = 1'b1; @(posedge clk); @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; be_n = 2'b00; addr = 10'd5;
    #0.5;
    expect_out("R6", 2'b00, 16'h0000);
    @(posedge clk); @(negedge clk);
    expect_out("R6", 2'b11, 16'h3C4D);

    // R9 reset clears outputs but keeps contents
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    expect_out("R9", 2'b00, 16'h0000);
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 2'b00, 10'd5, 16'h0000);
    expect_out("R9", 2'b11, 16'h3C4D);

    // Random mix over the preloaded pool, checked every cycle by the model
    for (int n = 0; n < 2000; n++) begin
      drive(($urandom % 6) == 0, 1'($urandom), 1'($urandom), 2'($urandom),
            pool_addr($urandom % 17), 16'($urandom));
    end

    running = 1'b0;
    finish_run();
  end

endmodule